// File: doc/BRIEF.md
# Down-Spread Modulation Profile Generator

This block produces, once per reference-clock cycle, a signed frequency-offset code that a downstream fractional divider or clock synthesizer turns into a spread-spectrum clock. The code describes a symmetric triangle that starts at zero offset, falls linearly to a peak negative offset, and climbs back to zero. The modulated clock's highest frequency therefore never exceeds the nominal input frequency. The offset is expressed in hundredths of a percent.

The peak depth comes from a lookup on two inputs. One is a decoded three-level spread selector. The other is a two-bit sub-band index that tells which part of the input-frequency range the reference lies in. The length of the triangle is a fixed number of reference cycles: 256 for the low input range and 512 for the high one. An active-low power-down stops the profile and drops both clock enables. Changes to the selector, sub-band or range are taken up only at the start of a new triangle, so each period is always complete and consistent.

Top module: `ssp_profile_top`

## Requirements
- R1: The offset output is never positive. It is exactly zero at phase 0 of every period.
- R2: One period spans 256 cycles when `range_hi`=0 and 512 cycles when `range_hi`=1. The offset is back at zero on the cycle that begins the next period.
- R3: With H = period/2 and peak magnitude P, the offset at phase k is −floor(P·k/H) for k ≤ H, and −floor(P·(2H−k)/H) for k > H. The offset reaches −P exactly at k = H.
- R4: With `lvl_sel`=2'b10 (high), P is 300, 270, 250 and 230 for `band` 0 to 3.
- R5: With `lvl_sel`=2'b00 (low), P is 220, 190, 180 and 170 for `band` 0 to 3.
- R6: With `lvl_sel`=2'b01 (middle), P is 70, 60, 60 and 50 for `band` 0 to 3. The code 2'b11 (undriven selector) behaves as middle.
- R7: While running, `mod_en` and `ref_en` are both 1. The reference enable never changes except together with the modulated enable.
- R8: One cycle after `pd_n` is sampled low, the offset is 0 and both `mod_en` and `ref_en` are 0. They stay that way while `pd_n` remains low.
- R9: After `pd_n` returns high, the first running cycle shows phase 0 (offset 0), and the profile then follows R3 from the start.
- R10: A change to `lvl_sel`, `band` or `range_hi` during a period has no effect until the next period boundary.
- R11: Synchronous active-high `rst` gives offset 0 and both enables 0. After reset is released with `pd_n` high, the profile begins at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_n | input | 1 | Power-down, active low |
| lvl_sel | input | 2 | Decoded spread level: 00 low, 01 middle, 10 high, 11 undriven (middle) |
| range_hi | input | 1 | Input range: 0 selects the 256-cycle period, 1 selects the 512-cycle period |
| band | input | 2 | Input-frequency sub-band index within the range |
| offset | output | 12 | Signed frequency offset, hundredths of a percent |
| mod_en | output | 1 | Modulated-output clock enable |
| ref_en | output | 1 | Unmodulated-reference clock enable |

## Verification
A phase counter that wraps at the wrong count shows up first as a zero offset on the wrong cycle. Within half a period it also shows up as a peak of the wrong size or on the wrong cycle. A stale or early-loaded depth register shows as a wrong peak value in the very period where the change should still be held off. A wrong power-down gating shows at the enables one cycle after the pin moves. The bench samples the offset at phase 0, H/2, H, 2H−1 and 2H for each configuration, so any such fault surfaces within one period.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int PEAK_W = 9;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_OPEN = 2'b11
    } spread_lvl_e;

    typedef struct packed {
        logic              range_hi;
        logic [PEAK_W-1:0] peak;
    } prof_cfg_t;

    // Peak down-spread magnitude in hundredths of a percent.
    function automatic logic [PEAK_W-1:0] peak_lookup(input spread_lvl_e lvl,
                                                      input logic [1:0] band);
        logic [PEAK_W-1:0] p;
        unique case (lvl)
            LVL_HIGH: begin
                unique case (band)
                    2'd0: p = 9'd300;
                    2'd1: p = 9'd270;
                    2'd2: p = 9'd250;
                    default: p = 9'd230;
                endcase
            end
            LVL_LOW: begin
                unique case (band)
                    2'd0: p = 9'd220;
                    2'd1: p = 9'd190;
                    2'd2: p = 9'd180;
                    default: p = 9'd170;
                endcase
            end
            default: begin
                unique case (band)
                    2'd0: p = 9'd70;
                    2'd1: p = 9'd60;
                    2'd2: p = 9'd60;
                    default: p = 9'd50;
                endcase
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ssp_cfg_latch.sv
module ssp_cfg_latch
    import ssp_pkg::*;
(
    input  logic        clk,
    input  logic        load,
    input  logic [1:0]  lvl_sel,
    input  logic [1:0]  band,
    input  logic        range_hi,
    output prof_cfg_t   cfg_q
);
    prof_cfg_t cfg_d;

    always_comb begin
        cfg_d.range_hi = range_hi;
        cfg_d.peak     = peak_lookup(spread_lvl_e'(lvl_sel), band);
    end

    always_ff @(posedge clk) begin
        if (load) cfg_q <= cfg_d;
    end
endmodule

// File: rtl/ssp_phase_ctr.sv
module ssp_phase_ctr #(
    parameter int LO_LOG2 = 8,
    parameter int HI_LOG2 = 9,
    localparam int PH_W   = HI_LOG2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            range_hi,
    output logic [PH_W-1:0] phase,
    output logic            wrap
);
    localparam logic [PH_W-1:0] LAST_LO = PH_W'((1 << LO_LOG2) - 1);
    localparam logic [PH_W-1:0] LAST_HI = PH_W'((1 << HI_LOG2) - 1);

    logic [PH_W-1:0] last;

    assign last = range_hi ? LAST_HI : LAST_LO;
    assign wrap = run && (phase == last);

    always_ff @(posedge clk) begin
        if (rst || !run)  phase <= '0;
        else if (wrap)    phase <= '0;
        else              phase <= phase + 1'b1;
    end
endmodule

// File: rtl/ssp_tri_shape.sv
module ssp_tri_shape
    import ssp_pkg::*;
#(
    parameter int LO_LOG2 = 8,
    parameter int HI_LOG2 = 9,
    localparam int PH_W   = HI_LOG2,
    localparam int PROD_W = PEAK_W + PH_W
) (
    input  logic [PH_W-1:0]   phase,
    input  prof_cfg_t         cfg,
    output logic [PEAK_W-1:0] mag
);
    localparam logic [PH_W:0] HALF_LO = (PH_W+1)'(1 << (LO_LOG2 - 1));
    localparam logic [PH_W:0] HALF_HI = (PH_W+1)'(1 << (HI_LOG2 - 1));

    logic [PH_W:0]   half;
    logic [PH_W:0]   k;
    logic [PROD_W:0] prod;
    logic [PROD_W:0] scaled;

    always_comb begin
        half = cfg.range_hi ? HALF_HI : HALF_LO;
        if ({1'b0, phase} <= half) k = {1'b0, phase};
        else                       k = (half << 1) - {1'b0, phase};
        prod   = (PROD_W+1)'(cfg.peak) * (PROD_W+1)'(k);
        scaled = cfg.range_hi ? (prod >> (HI_LOG2 - 1)) : (prod >> (LO_LOG2 - 1));
        mag    = scaled[PEAK_W-1:0];
    end
endmodule

// File: rtl/ssp_profile_top.sv
module ssp_profile_top
    import ssp_pkg::*;
#(
    parameter int LO_LOG2 = 8,
    parameter int HI_LOG2 = 9,
    parameter int OFS_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pd_n,
    input  logic [1:0]              lvl_sel,
    input  logic                    range_hi,
    input  logic [1:0]              band,
    output logic signed [OFS_W-1:0] offset,
    output logic                    mod_en,
    output logic                    ref_en
);
    localparam int PH_W = HI_LOG2;

    logic            run_q;
    logic            wrap;
    logic            load;
    logic [PH_W-1:0] phase;
    prof_cfg_t       cfg_q;
    logic [PEAK_W-1:0] mag;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= pd_n;
    end

    assign load = rst || !run_q || wrap;

    ssp_cfg_latch u_cfg (
        .clk      (clk),
        .load     (load),
        .lvl_sel  (lvl_sel),
        .band     (band),
        .range_hi (range_hi),
        .cfg_q    (cfg_q)
    );

    ssp_phase_ctr #(.LO_LOG2(LO_LOG2), .HI_LOG2(HI_LOG2)) u_ph (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .range_hi (cfg_q.range_hi),
        .phase    (phase),
        .wrap     (wrap)
    );

    ssp_tri_shape #(.LO_LOG2(LO_LOG2), .HI_LOG2(HI_LOG2)) u_tri (
        .phase (phase),
        .cfg   (cfg_q),
        .mag   (mag)
    );

    assign offset = run_q ? -$signed({{(OFS_W-PEAK_W){1'b0}}, mag}) : '0;
    assign mod_en = run_q;
    assign ref_en = run_q;
endmodule

// File: rtl/ssp_profile_chk.sv
module ssp_profile_chk #(
    parameter int OFS_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pd_n,
    input logic signed [OFS_W-1:0] offset,
    input logic                    mod_en,
    input logic                    ref_en
);
    a_r1_never_positive: assert property (@(posedge clk) disable iff (rst)
        offset <= 0);

    a_r8_pd_quiet: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (offset == 0 && !mod_en && !ref_en));

    a_r7_ref_tracks_mod: assert property (@(posedge clk) disable iff (rst)
        ref_en == mod_en);

    a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_en) |-> offset == 0);

    a_r3_small_step: assert property (@(posedge clk) disable iff (rst)
        (mod_en && $past(mod_en)) |->
            ((offset - $past(offset)) <= 3 && (offset - $past(offset)) >= -3));

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (offset == 0 && !mod_en && !ref_en));
endmodule

bind ssp_profile_top ssp_profile_chk #(.OFS_W(OFS_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .pd_n   (pd_n),
    .offset (offset),
    .mod_en (mod_en),
    .ref_en (ref_en)
);

// File: tb/ssp_profile_top_tb_top.sv
module ssp_profile_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // vector table: level, band, range, expected peak
    localparam logic [1:0] V_LVL [NV] = '{2'b10, 2'b10, 2'b10, 2'b10,
                                          2'b00, 2'b00, 2'b00, 2'b00,
                                          2'b01, 2'b01, 2'b01, 2'b11};
    localparam logic [1:0] V_BAND[NV] = '{2'd0, 2'd1, 2'd2, 2'd3,
                                          2'd0, 2'd1, 2'd2, 2'd3,
                                          2'd0, 2'd1, 2'd3, 2'd2};
    localparam logic       V_RNG [NV] = '{1'b0, 1'b1, 1'b0, 1'b1,
                                          1'b1, 1'b0, 1'b1, 1'b0,
                                          1'b0, 1'b1, 1'b0, 1'b1};
    localparam int         V_PEAK[NV] = '{300, 270, 250, 230,
                                          220, 190, 180, 170,
                                          70, 60, 50, 60};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_n = 1'b0;
    logic [1:0]  lvl_sel = 2'b10;
    logic        range_hi = 1'b0;
    logic [1:0]  band = 2'd0;
    logic signed [11:0] offset;
    logic        mod_en;
    logic        ref_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_profile_top dut_i (
        .clk(clk), .rst(rst), .pd_n(pd_n), .lvl_sel(lvl_sel),
        .range_hi(range_hi), .band(band), .offset(offset),
        .mod_en(mod_en), .ref_en(ref_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int shape(input int p, input int k, input int h);
        int kk;
        kk = (k <= h) ? k : 2*h - k;
        return -((p * kk) / h);
    endfunction

    // Power down, load config, release; returns at phase 0 sample point.
    task automatic start(input logic [1:0] l, input logic [1:0] b, input logic r);
        pd_n = 1'b0;
        step(2);
        lvl_sel = l; band = b; range_hi = r;
        step(1);
        pd_n = 1'b1;
        step(1);
    endtask

    initial begin
        step(3);
        // R11: reset state
        chk("R11 offset", int'(offset), 0);
        chk("R11 mod_en", int'(mod_en), 0);
        chk("R11 ref_en", int'(ref_en), 0);
        rst = 1'b0;
        step(1);

        // table walk: R4/R5/R6 peaks, R3 shape, R1 zero at phase 0, R7 enables
        for (int i = 0; i < NV; i++) begin
            int h;
            string tg;
            h = V_RNG[i] ? 256 : 128;
            tg = (V_LVL[i] == 2'b10) ? "R4" : (V_LVL[i] == 2'b00) ? "R5" : "R6";
            start(V_LVL[i], V_BAND[i], V_RNG[i]);
            chk("R1 phase0", int'(offset), 0);
            chk("R7 enables", int'(mod_en) + int'(ref_en), 2);
            step(h/2);
            chk("R3 quarter", int'(offset), shape(V_PEAK[i], h/2, h));
            step(h/2);
            chk({tg, " peak"}, int'(offset), -V_PEAK[i]);
        end

        // R2 period, low range
        start(2'b10, 2'd0, 1'b0);
        step(255);
        chk("R2 lo last", int'(offset), shape(300, 255, 128));
        step(1);
        chk("R2 lo wrap", int'(offset), 0);
        step(128);
        chk("R2 lo next peak", int'(offset), -300);

        // R2 period, high range
        start(2'b10, 2'd0, 1'b1);
        step(1);
        chk("R3 hi phase1", int'(offset), shape(300, 1, 256));
        step(510);
        chk("R2 hi last", int'(offset), shape(300, 511, 256));
        step(1);
        chk("R2 hi wrap", int'(offset), 0);

        // R10: level/band change mid period is deferred
        start(2'b10, 2'd0, 1'b0);
        step(10);
        lvl_sel = 2'b01; band = 2'd3;
        step(118);
        chk("R10 old peak kept", int'(offset), -300);
        step(256);
        chk("R10 new peak", int'(offset), -50);

        // R10: range change mid period is deferred
        start(2'b10, 2'd0, 1'b0);
        step(10);
        range_hi = 1'b1;
        step(118);
        chk("R10 old half", int'(offset), -300);
        step(128);
        chk("R10 old wrap", int'(offset), 0);
        step(128);
        chk("R10 new mid ramp", int'(offset), shape(300, 128, 256));
        step(128);
        chk("R10 new peak", int'(offset), -300);

        // R8: power-down mid period, R9: restart
        start(2'b00, 2'd1, 1'b0);
        step(40);
        pd_n = 1'b0;
        step(1);
        chk("R8 offset", int'(offset), 0);
        chk("R8 enables", int'(mod_en) + int'(ref_en), 0);
        step(5);
        chk("R8 held", int'(offset) + int'(mod_en) + int'(ref_en), 0);
        pd_n = 1'b1;
        step(1);
        chk("R9 restart zero", int'(offset), 0);
        chk("R9 enables", int'(mod_en) + int'(ref_en), 2);
        step(128);
        chk("R9 peak after restart", int'(offset), -190);

        // R11: reset mid-run then release starts at phase 0
        step(7);
        rst = 1'b1;
        step(1);
        chk("R11 reset offset", int'(offset), 0);
        chk("R11 reset enable", int'(mod_en), 0);
        rst = 1'b0;
        step(1);
        chk("R11 start phase0", int'(offset), 0);
        step(128);
        chk("R11 start peak", int'(offset), -190);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule